// File: doc/BRIEF.md
# Programmable Flash Sector Select Decoder

This block turns a system byte address into one select line per flash sector. The flash array is split into eight equal sectors of 16K bytes. Each sector's select is the OR of three address match terms that software sets up. Each term compares the upper address bits against a stored value under a bit mask. Because a sector has three terms, it can answer at up to three distinct places in the address map.

The block also holds one lock bit per sector. When the address falls in a locked sector, a flag is raised so that the flash command logic can drop program and erase requests to it. The low address bits are passed out as the byte offset within the sector. The term and lock storage is registered. Address decoding is purely combinational, so the selects follow the address within the same cycle.

Top module: `flash_sector_decoder`

## Requirements
- R1: The `offset` output always equals `addr[13:0]`, the byte index inside a 16K sector, whatever the configuration or `chip_en`.
- R2: An enabled term matches when `((addr[19:14] ^ value) & mask) == 0`. A mask bit of 1 means that address bit is compared, and a mask of 0 matches every address.
- R3: A sector is hit when any of its three terms matches, so one sector can be reached at several address regions.
- R4: A term whose enable bit is 0 never matches, whatever its value and mask.
- R5: While `chip_en` is 0, `sel`, `overlap` and `prot_hit` are all 0.
- R6: When more than one sector is hit, only the lowest-numbered sector's bit of `sel` is 1, and `overlap` is 1. Otherwise `overlap` is 0.
- R7: Each sector has a lock bit written through `prot_we`/`prot_sector`/`prot_value`. `prot_hit` is 1 exactly when the driven select belongs to a locked sector.
- R8: With `cfg_we` high at a rising clock edge, the term at (`cfg_sector`, `cfg_term`) takes `cfg_value`, `cfg_mask` and `cfg_enable`, and is used from that edge on. A write with `cfg_term` equal to 3 changes nothing.
- R9: After reset, every term is disabled and every sector is unlocked, so `sel` is 0 for every address.
- R10: At most one bit of `sel` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 20 | System byte address |
| chip_en | input | 1 | Qualifies the decode; selects are low while it is 0 |
| cfg_we | input | 1 | Term write strobe |
| cfg_sector | input | 3 | Sector whose term is written |
| cfg_term | input | 2 | Term index 0 to 2 within the sector |
| cfg_value | input | 6 | Compare value for the upper address bits |
| cfg_mask | input | 6 | Compare mask, 1 means the bit is compared |
| cfg_enable | input | 1 | Term enable |
| prot_we | input | 1 | Lock write strobe |
| prot_sector | input | 3 | Sector whose lock bit is written |
| prot_value | input | 1 | New lock bit |
| sel | output | 8 | One-hot sector selects, bit n for sector n |
| overlap | output | 1 | More than one sector matched the address |
| prot_hit | output | 1 | The driven sector is locked |
| offset | output | 14 | Byte offset within the sector |

## Verification
A corrupted term register shows up as a wrong or missing select bit. This happens in the same cycle that an address in the affected region is presented, so every check places an address in each configured region and in gaps next to it. A corrupted lock bit appears only through `prot_hit`, and only while the address falls in that sector. The bench therefore checks locks on sectors that win an overlap and on sectors that lose one. Resolver faults appear as two select bits at once or as a wrong winner, and these are checked in the same cycle as the address.

// File: rtl/flash_sel_pkg.sv
package flash_sel_pkg;

    localparam int DEF_ADDR_W   = 20;
    localparam int DEF_OFFSET_W = 14;
    localparam int DEF_SECTORS  = 8;
    localparam int DEF_TERMS    = 3;

    // Compare a masked field; a set mask bit means "care".
    function automatic logic field_match(
        input logic [31:0] a,
        input logic [31:0] v,
        input logic [31:0] m
    );
        return ((a ^ v) & m) == 32'd0;
    endfunction

endpackage

// File: rtl/flash_sel_cfg.sv
module flash_sel_cfg #(
    parameter int SECTORS = flash_sel_pkg::DEF_SECTORS,
    parameter int TERMS   = flash_sel_pkg::DEF_TERMS,
    parameter int UPPER_W = 6,
    localparam int SW     = $clog2(SECTORS),
    localparam int TW     = (TERMS > 1) ? $clog2(TERMS + 1) : 1,
    localparam int NT     = SECTORS * TERMS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SW-1:0]      cfg_sector,
    input  logic [TW-1:0]      cfg_term,
    input  logic [UPPER_W-1:0] cfg_value,
    input  logic [UPPER_W-1:0] cfg_mask,
    input  logic               cfg_enable,
    input  logic               prot_we,
    input  logic [SW-1:0]      prot_sector,
    input  logic               prot_value,
    output logic [NT-1:0]         term_en,
    output logic [NT*UPPER_W-1:0] term_val,
    output logic [NT*UPPER_W-1:0] term_msk,
    output logic [SECTORS-1:0]    lock
);

    typedef struct packed {
        logic               en;
        logic [UPPER_W-1:0] val;
        logic [UPPER_W-1:0] msk;
    } term_t;

    typedef struct packed {
        term_t [NT-1:0]     terms;
        logic [SECTORS-1:0] lock;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NT; i++) begin
            if (cfg_we && (int'(cfg_term) < TERMS) &&
                (int'(cfg_sector) * TERMS + int'(cfg_term) == i)) begin
                st_d.terms[i].en  = cfg_enable;
                st_d.terms[i].val = cfg_value;
                st_d.terms[i].msk = cfg_mask;
            end
        end
        for (int s = 0; s < SECTORS; s++) begin
            if (prot_we && (int'(prot_sector) == s)) begin
                st_d.lock[s] = prot_value;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NT; i++) begin : g_out
        assign term_en[i]                       = st_q.terms[i].en;
        assign term_val[i*UPPER_W +: UPPER_W]   = st_q.terms[i].val;
        assign term_msk[i*UPPER_W +: UPPER_W]   = st_q.terms[i].msk;
    end
    assign lock = st_q.lock;

endmodule

// File: rtl/flash_sel_term.sv
module flash_sel_term #(
    parameter int UPPER_W = 6
) (
    input  logic [UPPER_W-1:0] addr_hi,
    input  logic               en,
    input  logic [UPPER_W-1:0] val,
    input  logic [UPPER_W-1:0] msk,
    output logic               hit
);

    logic [31:0] a_w, v_w, m_w;

    always_comb begin
        a_w = 32'(addr_hi);
        v_w = 32'(val);
        m_w = 32'(msk);
        hit = en && flash_sel_pkg::field_match(a_w, v_w, m_w);
    end

endmodule

// File: rtl/flash_sel_prio.sv
module flash_sel_prio #(
    parameter int SECTORS = flash_sel_pkg::DEF_SECTORS
) (
    input  logic [SECTORS-1:0] raw,
    output logic [SECTORS-1:0] win,
    output logic               multi
);

    // Isolate the lowest set bit: raw & two's complement of raw.
    always_comb begin
        win   = raw & (~raw + SECTORS'(1));
        multi = |(raw & ~win);
    end

endmodule

// File: rtl/flash_sector_decoder.sv
module flash_sector_decoder #(
    parameter int ADDR_W   = flash_sel_pkg::DEF_ADDR_W,
    parameter int OFFSET_W = flash_sel_pkg::DEF_OFFSET_W,
    parameter int SECTORS  = flash_sel_pkg::DEF_SECTORS,
    parameter int TERMS    = flash_sel_pkg::DEF_TERMS,
    localparam int UPPER_W = ADDR_W - OFFSET_W,
    localparam int SW      = $clog2(SECTORS),
    localparam int TW      = (TERMS > 1) ? $clog2(TERMS + 1) : 1,
    localparam int NT      = SECTORS * TERMS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                chip_en,
    input  logic                cfg_we,
    input  logic [SW-1:0]       cfg_sector,
    input  logic [TW-1:0]       cfg_term,
    input  logic [UPPER_W-1:0]  cfg_value,
    input  logic [UPPER_W-1:0]  cfg_mask,
    input  logic                cfg_enable,
    input  logic                prot_we,
    input  logic [SW-1:0]       prot_sector,
    input  logic                prot_value,
    output logic [SECTORS-1:0]  sel,
    output logic                overlap,
    output logic                prot_hit,
    output logic [OFFSET_W-1:0] offset
);

    logic [NT-1:0]         term_en;
    logic [NT*UPPER_W-1:0] term_val;
    logic [NT*UPPER_W-1:0] term_msk;
    logic [SECTORS-1:0]    lock;
    logic [NT-1:0]         term_hit;
    logic [SECTORS-1:0]    raw_hit;
    logic [UPPER_W-1:0]    addr_hi;

    assign addr_hi = addr[ADDR_W-1:OFFSET_W];
    assign offset  = addr[OFFSET_W-1:0];

    flash_sel_cfg #(
        .SECTORS (SECTORS),
        .TERMS   (TERMS),
        .UPPER_W (UPPER_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sector  (cfg_sector),
        .cfg_term    (cfg_term),
        .cfg_value   (cfg_value),
        .cfg_mask    (cfg_mask),
        .cfg_enable  (cfg_enable),
        .prot_we     (prot_we),
        .prot_sector (prot_sector),
        .prot_value  (prot_value),
        .term_en     (term_en),
        .term_val    (term_val),
        .term_msk    (term_msk),
        .lock        (lock)
    );

    for (genvar s = 0; s < SECTORS; s++) begin : g_sec
        for (genvar t = 0; t < TERMS; t++) begin : g_term
            localparam int IDX = s * TERMS + t;
            flash_sel_term #(
                .UPPER_W (UPPER_W)
            ) u_term (
                .addr_hi (addr_hi),
                .en      (term_en[IDX]),
                .val     (term_val[IDX*UPPER_W +: UPPER_W]),
                .msk     (term_msk[IDX*UPPER_W +: UPPER_W]),
                .hit     (term_hit[IDX])
            );
        end
        assign raw_hit[s] = chip_en && (|term_hit[s*TERMS +: TERMS]);
    end

    flash_sel_prio #(
        .SECTORS (SECTORS)
    ) u_prio (
        .raw   (raw_hit),
        .win   (sel),
        .multi (overlap)
    );

    assign prot_hit = |(sel & lock);

endmodule

// File: rtl/flash_sector_decoder_chk.sv
module flash_sector_decoder_chk #(
    parameter int SECTORS = 8,
    parameter int SW      = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               chip_en,
    input logic               prot_we,
    input logic [SW-1:0]      prot_sector,
    input logic               prot_value,
    input logic [SECTORS-1:0] sel,
    input logic               overlap,
    input logic               prot_hit
);

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R5
    chip_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> (sel == '0 && !overlap && !prot_hit));

    // R6
    overlap_has_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overlap |-> ($countones(sel) == 1));

    // R7
    lock_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_hit |-> (sel != '0));

    for (genvar s = 0; s < SECTORS; s++) begin : g_lock
        // R7
        lock_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (prot_we && int'(prot_sector) == s && prot_value) |=> (!sel[s] || prot_hit));
    end

endmodule

bind flash_sector_decoder flash_sector_decoder_chk #(
    .SECTORS (SECTORS),
    .SW      (SW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en     (chip_en),
    .prot_we     (prot_we),
    .prot_sector (prot_sector),
    .prot_value  (prot_value),
    .sel         (sel),
    .overlap     (overlap),
    .prot_hit    (prot_hit)
);

// File: tb/sim_flash_sector_decoder.sv
module sim_flash_sector_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        chip_en = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sector = '0;
    logic [1:0]  cfg_term = '0;
    logic [5:0]  cfg_value = '0;
    logic [5:0]  cfg_mask = '0;
    logic        cfg_enable = 1'b0;
    logic        prot_we = 1'b0;
    logic [2:0]  prot_sector = '0;
    logic        prot_value = 1'b0;
    logic [7:0]  sel;
    logic        overlap;
    logic        prot_hit;
    logic [13:0] offset;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    flash_sector_decoder u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .chip_en(chip_en),
        .cfg_we(cfg_we), .cfg_sector(cfg_sector), .cfg_term(cfg_term),
        .cfg_value(cfg_value), .cfg_mask(cfg_mask), .cfg_enable(cfg_enable),
        .prot_we(prot_we), .prot_sector(prot_sector), .prot_value(prot_value),
        .sel(sel), .overlap(overlap), .prot_hit(prot_hit), .offset(offset)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic probe(input string req, input logic [19:0] a,
                         input logic [7:0] e_sel, input logic e_ovl, input logic e_prot);
        @(negedge clk);
        addr = a;
        #1;
        check({req, " sel"}, 32'(sel), 32'(e_sel));
        check({req, " overlap"}, 32'(overlap), 32'(e_ovl));
        check({req, " prot_hit"}, 32'(prot_hit), 32'(e_prot));
    endtask

    task automatic write_term(input int s, input int t, input logic [5:0] v,
                              input logic [5:0] m, input logic en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sector = 3'(s); cfg_term = 2'(t);
        cfg_value = v; cfg_mask = m; cfg_enable = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_lock(input int s, input logic v);
        @(negedge clk);
        prot_we = 1'b1; prot_sector = 3'(s); prot_value = v;
        @(negedge clk);
        prot_we = 1'b0;
    endtask

    task automatic t_reset();
        probe("R9", 20'h00000, 8'h00, 1'b0, 1'b0);
        probe("R9", 20'h40000, 8'h00, 1'b0, 1'b0);
        probe("R9", 20'hFC000, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_offset();
        @(negedge clk);
        addr = 20'hABCDE; #1;
        check("R1 offset", 32'(offset), 32'h3CDE);
        chip_en = 1'b0; addr = 20'h07FFF; #1;
        check("R1 offset chip off", 32'(offset), 32'h3FFF);
        chip_en = 1'b1;
    endtask

    task automatic t_basic();
        write_term(0, 0, 6'h00, 6'h3F, 1'b1);
        probe("R2 exact hit", 20'h00123, 8'h01, 1'b0, 1'b0);
        probe("R2 exact miss", 20'h04000, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_alias();
        write_term(3, 0, 6'h10, 6'h3F, 1'b1);
        write_term(3, 1, 6'h20, 6'h3F, 1'b1);
        write_term(3, 2, 6'h30, 6'h3F, 1'b1);
        probe("R3 alias term0", 20'h40000, 8'h08, 1'b0, 1'b0);
        probe("R3 alias term1", 20'h80000, 8'h08, 1'b0, 1'b0);
        probe("R3 alias term2", 20'hC0000, 8'h08, 1'b0, 1'b0);
        write_term(5, 0, 6'h08, 6'h38, 1'b1);
        probe("R2 partial mask hit", 20'h2C000, 8'h20, 1'b0, 1'b0);
        probe("R2 partial mask miss", 20'h44000, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_disable();
        write_term(3, 1, 6'h20, 6'h3F, 1'b0);
        probe("R4 disabled term", 20'h80000, 8'h00, 1'b0, 1'b0);
        probe("R4 sibling kept", 20'h40000, 8'h08, 1'b0, 1'b0);
    endtask

    task automatic t_chip_off();
        @(negedge clk);
        chip_en = 1'b0;
        probe("R5 chip off", 20'h00123, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        chip_en = 1'b1;
    endtask

    task automatic t_overlap();
        write_term(6, 2, 6'h10, 6'h3F, 1'b1);
        probe("R6 two hit", 20'h40000, 8'h08, 1'b1, 1'b0);
        write_term(1, 0, 6'h00, 6'h00, 1'b1);
        probe("R6 catch-all wins", 20'h40000, 8'h02, 1'b1, 1'b0);
        probe("R6 catch-all over 5", 20'h2C000, 8'h02, 1'b1, 1'b0);
        write_term(1, 0, 6'h00, 6'h00, 1'b0);
        probe("R6 single no overlap", 20'hC0000, 8'h08, 1'b0, 1'b0);
    endtask

    task automatic t_lock();
        write_lock(3, 1'b1);
        probe("R7 locked sector", 20'hC0000, 8'h08, 1'b0, 1'b1);
        probe("R7 other unlocked", 20'h00123, 8'h01, 1'b0, 1'b0);
        write_lock(3, 1'b0);
        probe("R7 unlocked again", 20'hC0000, 8'h08, 1'b0, 1'b0);
        write_lock(6, 1'b1);
        probe("R7 loser locked", 20'h40000, 8'h08, 1'b1, 1'b0);
        write_lock(0, 1'b1);
        @(negedge clk);
        chip_en = 1'b0;
        probe("R5 lock chip off", 20'h00123, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        chip_en = 1'b1;
        probe("R7 sector0 locked", 20'h00123, 8'h01, 1'b0, 1'b1);
    endtask

    task automatic t_term3();
        write_term(2, 3, 6'h3F, 6'h3F, 1'b1);
        probe("R8 term3 ignored", 20'hFC000, 8'h00, 1'b0, 1'b0);
        write_term(2, 2, 6'h3F, 6'h3F, 1'b1);
        probe("R8 term2 written", 20'hFC000, 8'h04, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_offset();
        t_basic();
        t_alias();
        t_disable();
        t_chip_off();
        t_overlap();
        t_lock();
        t_term3();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule